// File: doc/BRIEF.md
# Real-Time Monitor Serial Streamer

This block sends a short diagnostic burst out of a chip on two pins. A single-cycle start pulse, raised when the compute sequence reaches the state in which results are final, copies a set of parallel data words into a private shadow store. The block then plays those words out one bit per clock on a serial data line. A separate marker line pulses once ahead of each word, and a strobe line changes level each time a new data bit appears.

The whole burst fits inside a fixed window of clock cycles that is shorter than one compute pass, so one burst ends before the next pass can request another. The window holds the marker and data slots followed by a short quiet tail. A busy output covers the whole window. A start pulse that arrives while busy is dropped and sets a sticky overrun indication, which stays set until a clear input is pulsed.

The words are buffered at the start pulse, so the producer may update its outputs as soon as it has issued the pulse. The default build sends four 32-bit words in a 140-cycle window.

Top module: `rtm_streamer`

## Requirements
- R1: After reset, busy_o, flag_o, data_o, strobe_o and overrun_o are all low.
- R2: If start_i is high at a rising edge while busy_o is low, the burst is accepted, and in the next cycle busy_o is high, flag_o is high and data_o is low.
- R3: busy_o stays high for exactly WINDOW consecutive cycles per accepted start (140 by default).
- R4: Each word occupies a slot of WORD_W+1 cycles. In the first cycle of the slot flag_o is high and data_o is low. In the next WORD_W cycles flag_o is low and data_o carries bits 0, 1, ... WORD_W-1 of the word, in that order.
- R5: Slots follow in word index order 0 to NUM_WORDS-1, where word k is words_i[k*WORD_W +: WORD_W].
- R6: After the last slot, the remaining WINDOW - NUM_WORDS*(WORD_W+1) cycles of the window (8 by default) have flag_o and data_o low while busy_o stays high.
- R7: words_i is sampled only at the edge that accepts a start, so a change to words_i during a burst does not alter the bits sent.
- R8: strobe_o inverts in exactly those cycles in which a new data bit appears on data_o, and holds its level in all other cycles (128 inversions per default burst).
- R9: A start_i pulse seen while busy_o is high does not restart or lengthen the burst and does not reload the words. It sets overrun_o high from the next cycle.
- R10: overrun_o stays high until clr_ovr_i is high at an edge, after which it is low. If a dropped start and clr_ovr_i occur at the same edge, overrun_o ends up high.
- R11: A start_i pulse at the edge where busy_o is already low again, immediately after a window, is accepted, so bursts can run back to back.
- R12: While busy_o is low, flag_o and data_o are low and strobe_o holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst request pulse |
| clr_ovr_i | input | 1 | Clears the overrun indication |
| words_i | input | NUM_WORDS*WORD_W | Parallel data words; word k is in bits k*WORD_W +: WORD_W |
| flag_o | output | 1 | Marker, high in the cycle before each word's first bit |
| data_o | output | 1 | Serial data, least significant bit of each word first |
| strobe_o | output | 1 | Inverts with each new data bit |
| busy_o | output | 1 | High for the whole burst window |
| overrun_o | output | 1 | Sticky: a start was dropped while busy |

## Verification
The bench uses the default build: four 32-bit words in a 140-cycle window. At this size a walking one can visit every one of the 128 bit positions, each in its own burst, so every slot and bit index is confirmed to reach the right cycle. The same build also allows dropped starts at the first marker cycle, mid-slot, the first tail cycle and the last busy cycle. Back-to-back bursts are covered, along with a clear that coincides with a dropped start.

// File: rtl/rtm_pkg.sv
`timescale 1ns/1ps
package rtm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SLOT = 2'd1,
        PH_TAIL = 2'd2
    } rtm_phase_e;

    // Control bundle passed from the sequencer to the line stage
    typedef struct packed {
        logic busy;     // window active
        logic flag;     // marker cycle of a slot
        logic data_en;  // a data bit is on the line this cycle
        logic launch;   // next cycle presents a fresh data bit
        logic accept;   // start taken at this edge
        logic reject;   // start dropped at this edge
    } rtm_ctl_t;

    function automatic int slot_len(input int word_w);
        return word_w + 1;
    endfunction

    function automatic int active_len(input int n_words, input int word_w);
        return n_words * slot_len(word_w);
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rtm_seq.sv
`timescale 1ns/1ps
module rtm_seq
    import rtm_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32,
    parameter int IDLE_LEN  = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start_i,
    output rtm_ctl_t                            ctl_o,
    output logic [idx_width(NUM_WORDS)-1:0]     word_sel_o,
    output logic [idx_width(WORD_W)-1:0]        bit_sel_o
);
    localparam int WIDX_W = idx_width(NUM_WORDS);
    localparam int BIT_W  = idx_width(WORD_W);
    localparam int POS_W  = $clog2(WORD_W + 1);
    localparam int TAIL_W = idx_width(IDLE_LEN);

    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(WORD_W);
    localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(NUM_WORDS - 1);
    localparam logic [TAIL_W-1:0] TAIL_LAST = TAIL_W'(IDLE_LEN - 1);

    rtm_phase_e          phase_q, phase_d;
    logic [WIDX_W-1:0]   widx_q, widx_d;
    logic [POS_W-1:0]    pos_q, pos_d;
    logic [TAIL_W-1:0]   tail_q, tail_d;
    logic [POS_W-1:0]    pos_m1;

    always_comb begin
        phase_d = phase_q;
        widx_d  = widx_q;
        pos_d   = pos_q;
        tail_d  = tail_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    phase_d = PH_SLOT;
                    widx_d  = '0;
                    pos_d   = '0;
                end
            end
            PH_SLOT: begin
                if (pos_q == POS_LAST) begin
                    pos_d = '0;
                    if (widx_q == WIDX_LAST) begin
                        phase_d = PH_TAIL;
                        widx_d  = '0;
                        tail_d  = '0;
                    end else begin
                        widx_d = widx_q + WIDX_W'(1);
                    end
                end else begin
                    pos_d = pos_q + POS_W'(1);
                end
            end
            PH_TAIL: begin
                if (tail_q == TAIL_LAST) begin
                    phase_d = PH_IDLE;
                end else begin
                    tail_d = tail_q + TAIL_W'(1);
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            widx_q  <= '0;
            pos_q   <= '0;
            tail_q  <= '0;
        end else begin
            phase_q <= phase_d;
            widx_q  <= widx_d;
            pos_q   <= pos_d;
            tail_q  <= tail_d;
        end
    end

    always_comb begin
        ctl_o.busy    = (phase_q != PH_IDLE);
        ctl_o.flag    = (phase_q == PH_SLOT) && (pos_q == '0);
        ctl_o.data_en = (phase_q == PH_SLOT) && (pos_q != '0);
        ctl_o.launch  = (phase_d == PH_SLOT) && (pos_d != '0);
        ctl_o.accept  = start_i && (phase_q == PH_IDLE);
        ctl_o.reject  = start_i && (phase_q != PH_IDLE);
    end

    assign pos_m1     = pos_q - POS_W'(1);
    assign bit_sel_o  = pos_m1[BIT_W-1:0];
    assign word_sel_o = widx_q;

endmodule

// File: rtl/rtm_shadow.sv
`timescale 1ns/1ps
module rtm_shadow
    import rtm_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load_i,
    input  logic [NUM_WORDS*WORD_W-1:0]       words_i,
    input  logic [idx_width(NUM_WORDS)-1:0]   word_sel_i,
    input  logic [idx_width(WORD_W)-1:0]      bit_sel_i,
    input  logic                              en_i,
    output logic                              bit_o
);
    logic [WORD_W-1:0] shadow_q [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[g] <= '0;
            end else if (load_i) begin
                shadow_q[g] <= words_i[g*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        bit_o = 1'b0;
        if (en_i) begin
            bit_o = shadow_q[word_sel_i][bit_sel_i];
        end
    end

endmodule

// File: rtl/rtm_line.sv
`timescale 1ns/1ps
module rtm_line
    import rtm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rtm_ctl_t ctl_i,
    input  logic     bit_i,
    input  logic     clr_ovr_i,
    output logic     flag_o,
    output logic     data_o,
    output logic     strobe_o,
    output logic     busy_o,
    output logic     overrun_o
);
    logic strobe_q;
    logic ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            if (ctl_i.launch) begin
                strobe_q <= ~strobe_q;
            end
            if (ctl_i.reject) begin
                ovr_q <= 1'b1;
            end else if (clr_ovr_i) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign flag_o    = ctl_i.flag;
    assign data_o    = ctl_i.data_en & bit_i;
    assign busy_o    = ctl_i.busy;
    assign strobe_o  = strobe_q;
    assign overrun_o = ovr_q;

endmodule

// File: rtl/rtm_streamer.sv
`timescale 1ns/1ps
module rtm_streamer
    import rtm_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32,
    parameter int WINDOW    = 140
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic                          clr_ovr_i,
    input  logic [NUM_WORDS*WORD_W-1:0]   words_i,
    output logic                          flag_o,
    output logic                          data_o,
    output logic                          strobe_o,
    output logic                          busy_o,
    output logic                          overrun_o
);
    localparam int ACTIVE   = active_len(NUM_WORDS, WORD_W);
    localparam int IDLE_LEN = WINDOW - ACTIVE;
    localparam int WIDX_W   = idx_width(NUM_WORDS);
    localparam int BIT_W    = idx_width(WORD_W);

    if (IDLE_LEN < 1) begin : g_bad_window
        $error("rtm_streamer: WINDOW must exceed NUM_WORDS*(WORD_W+1)");
    end

    rtm_ctl_t          ctl;
    logic [WIDX_W-1:0] word_sel;
    logic [BIT_W-1:0]  bit_sel;
    logic              shadow_bit;

    rtm_seq #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .IDLE_LEN  (IDLE_LEN)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .ctl_o      (ctl),
        .word_sel_o (word_sel),
        .bit_sel_o  (bit_sel)
    );

    rtm_shadow #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) shadow_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ctl.accept),
        .words_i    (words_i),
        .word_sel_i (word_sel),
        .bit_sel_i  (bit_sel),
        .en_i       (ctl.data_en),
        .bit_o      (shadow_bit)
    );

    rtm_line line_i (
        .clk       (clk),
        .rst       (rst),
        .ctl_i     (ctl),
        .bit_i     (shadow_bit),
        .clr_ovr_i (clr_ovr_i),
        .flag_o    (flag_o),
        .data_o    (data_o),
        .strobe_o  (strobe_o),
        .busy_o    (busy_o),
        .overrun_o (overrun_o)
    );

endmodule

// File: rtl/rtm_streamer_chk.sv
`timescale 1ns/1ps
module rtm_streamer_chk #(
    parameter int WINDOW = 140
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic clr_ovr_i,
    input logic flag_o,
    input logic data_o,
    input logic strobe_o,
    input logic busy_o,
    input logic overrun_o
);
    // Length of the current busy run, checked against the window
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + 16'd1;
        end else begin
            run_q <= '0;
        end
    end

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && flag_o && !data_o));

    assert_busy_within_window_R3: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run_q < 16'(WINDOW)));

    assert_busy_full_window_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && run_q != 16'd0) |-> (run_q == 16'(WINDOW)));

    assert_flag_data_low_R4: assert property (@(posedge clk) disable iff (rst)
        flag_o |-> !data_o);

    assert_flag_single_R4: assert property (@(posedge clk) disable iff (rst)
        flag_o |=> (busy_o && !flag_o));

    assert_strobe_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> $stable(strobe_o));

    assert_strobe_hold_flag_R8: assert property (@(posedge clk) disable iff (rst)
        flag_o |-> $stable(strobe_o));

    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o) |=> overrun_o);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !clr_ovr_i) |=> overrun_o);

    assert_overrun_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_ovr_i && !(start_i && busy_o)) |=> !overrun_o);

    assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!flag_o && !data_o));

endmodule

bind rtm_streamer rtm_streamer_chk #(.WINDOW(WINDOW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .clr_ovr_i (clr_ovr_i),
    .flag_o    (flag_o),
    .data_o    (data_o),
    .strobe_o  (strobe_o),
    .busy_o    (busy_o),
    .overrun_o (overrun_o)
);

// File: tb/rtm_streamer_tb.sv
`timescale 1ns/1ps
module rtm_streamer_tb_top;
    localparam int NW  = 4;
    localparam int WW  = 32;
    localparam int WIN = 140;
    localparam int SLOT = WW + 1;
    localparam int ACT  = NW * SLOT;

    logic clk = 1'b0;
    logic rst;
    logic start_i;
    logic clr_ovr_i;
    logic [NW*WW-1:0] words_i;
    logic flag_o, data_o, strobe_o, busy_o, overrun_o;

    int checks = 0;
    int fails  = 0;
    logic exp_strobe = 1'b0;
    logic exp_ovr    = 1'b0;

    always #2 clk = ~clk;

    rtm_streamer #(.NUM_WORDS(NW), .WORD_W(WW), .WINDOW(WIN)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .clr_ovr_i (clr_ovr_i),
        .words_i   (words_i),
        .flag_o    (flag_o),
        .data_o    (data_o),
        .strobe_o  (strobe_o),
        .busy_o    (busy_o),
        .overrun_o (overrun_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    // Quiet cycles outside a burst; words_i wiggles to show it has no effect
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            chk("R12 busy", 32'(busy_o), 32'd0);
            chk("R12 flag", 32'(flag_o), 32'd0);
            chk("R12 data", 32'(data_o), 32'd0);
            chk("R12 strobe", 32'(strobe_o), 32'(exp_strobe));
            chk("R10 overrun idle", 32'(overrun_o), 32'(exp_ovr));
            words_i = {NW{32'(i) * 32'h9E3779B9}};
            @(negedge clk);
        end
    endtask

    task automatic clear_ovr();
        clr_ovr_i = 1'b1;
        @(negedge clk);
        clr_ovr_i = 1'b0;
        exp_ovr = 1'b0;
        chk("R10 cleared", 32'(overrun_o), 32'd0);
    endtask

    // Entered at a negedge with busy_o low; returns at the negedge after the window
    task automatic burst(input logic [NW*WW-1:0] wv, input int poke, input bit mutate,
                         input bit clr_same);
        words_i = wv;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < WIN; c++) begin
            int  w = c / SLOT;
            int  p = c % SLOT;
            logic ef, ed;
            if (c < ACT) begin
                ef = (p == 0);
                ed = (p == 0) ? 1'b0 : wv[w*WW + p - 1];
                if (p != 0) exp_strobe = ~exp_strobe;
            end else begin
                ef = 1'b0;
                ed = 1'b0;
            end
            chk((c == 0) ? "R2 busy" : "R3 busy", 32'(busy_o), 32'd1);
            chk((c < ACT) ? "R4 flag" : "R6 flag", 32'(flag_o), 32'(ef));
            chk((c < ACT) ? (mutate ? "R7 data" : "R5 data") : "R6 data",
                32'(data_o), 32'(ed));
            chk("R8 strobe", 32'(strobe_o), 32'(exp_strobe));
            chk("R9 overrun", 32'(overrun_o), 32'(exp_ovr));
            start_i   = (c == poke);
            clr_ovr_i = (c == poke) && clr_same;
            if (c == poke) exp_ovr = 1'b1;
            if (mutate && c == 5) words_i = ~wv;
            @(negedge clk);
        end
        start_i   = 1'b0;
        clr_ovr_i = 1'b0;
        chk("R3 busy end", 32'(busy_o), 32'd0);
        chk("R10 overrun end", 32'(overrun_o), 32'(exp_ovr));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start_i = 1'b0;
        clr_ovr_i = 1'b0;
        words_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 flag", 32'(flag_o), 32'd0);
        chk("R1 data", 32'(data_o), 32'd0);
        chk("R1 strobe", 32'(strobe_o), 32'd0);
        chk("R1 overrun", 32'(overrun_o), 32'd0);
        idle(4);

        // Fixed patterns
        burst('0, -1, 1'b0, 1'b0);
        idle(2);
        burst('1, -1, 1'b0, 1'b0);
        idle(2);
        burst({NW{32'h5555_AAAA}}, -1, 1'b0, 1'b0);
        // R11: back-to-back, no idle gap
        burst({32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'hF0F0_0F0F}, -1, 1'b0, 1'b0);

        // R5/R4: walking one over every bit position
        for (int k = 0; k < NW*WW; k++) begin
            logic [NW*WW-1:0] v;
            v = '0;
            v[k] = 1'b1;
            burst(v, -1, 1'b0, 1'b0);
        end
        idle(3);

        // R7: input changes mid-burst
        burst({NW{32'hC3A5_965A}}, -1, 1'b1, 1'b0);
        idle(2);

        // R9/R10: dropped starts at several points, sticky, then cleared
        burst({32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888}, 0, 1'b0, 1'b0);
        idle(5);
        clear_ovr();
        burst({NW{32'h0F1E_2D3C}}, 50, 1'b0, 1'b0);
        clear_ovr();
        burst({NW{32'hA0B1_C2D3}}, ACT, 1'b0, 1'b0);
        clear_ovr();
        burst({NW{32'h7E57_0001}}, WIN - 1, 1'b1, 1'b0);
        clear_ovr();
        // R10: set wins over a simultaneous clear
        burst({NW{32'h2468_ACE0}}, 70, 1'b0, 1'b1);
        idle(2);
        clear_ovr();
        idle(2);

        // Hashed words, back to back
        for (int s = 0; s < 6; s++) begin
            logic [NW*WW-1:0] v;
            for (int j = 0; j < NW; j++) v[j*WW +: WW] = 32'(s*NW + j + 1) * 32'h9E3779B9;
            burst(v, -1, 1'b0, 1'b0);
        end
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule